// File: doc/BRIEF.md
# Dual-Path Legacy Card Control Register File

This block holds one socket's bank of 64 byte-wide control registers and makes the same storage reachable from two host paths. The legacy indexed path uses two adjacent I/O addresses. The host writes a register number to the first address (the index port). It then reads or writes the selected register through the second address (the data port). The memory path maps the same bank as a direct alias starting at offset 800h of a 4 KB window. Offset 0h of that window holds a separate group of socket registers with its own storage.

The host side is a plain synchronous bus. Each access is a single-cycle write strobe or read strobe, qualified by a path select (I/O or memory), an address and write data. Read data is registered and appears on the cycle after the read strobe.

Two reset inputs act on the block. The global reset clears everything. The ordinary reset clears all state except bits marked sticky and the index. This lets control context survive a power-state transition.

Top module: `lcr_regfile`

## Requirements
- R1: An I/O write to the base address (default 3E0h) loads all 8 bits of the write data into the index, and an I/O read at the base address returns the index.
- R2: An I/O access at base + 1 reads or writes the bank register whose number equals the index, for index values 00h to 3Fh.
- R3: While the index is 40h or above, an I/O read at base + 1 returns 00h, and an I/O write there changes no register.
- R4: A memory access at window offset 800h + n (n from 00h to 3Fh) reaches bank register n. A value written through either path is returned by the next read through the other path.
- R5: Memory offsets 00h to 1Fh reach a separate 32-byte socket register group, and a write there leaves every bank register unchanged.
- R6: Memory accesses at offsets 20h to 7FFh and 840h to FFFh, and I/O accesses at any address other than base and base + 1, read as 00h and change no register and not the index.
- R7: Read data is presented on bus_rdata on the cycle after the read strobe and holds its value until the next read strobe or reset.
- R8: The ordinary reset clears read data, all socket registers and every non-sticky bank bit. It leaves the index and the sticky bits unchanged. By default the sticky bits are register 05h bits 3:0 and register 20h bits 7:4.
- R9: The global reset clears the index, read data and every register bit, sticky bits included, to 0.
- R10: The memory path decodes only the low 12 address bits, so offset 1805h reaches bank register 05h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_glob_n | input | 1 | Global reset, active low, synchronous; clears all state |
| rst_pwr_n | input | 1 | Ordinary reset, active low, synchronous; spares sticky bits and index |
| bus_io | input | 1 | Path select: 1 = I/O access, 0 = memory window access |
| bus_addr | input | 16 | I/O address, or memory window offset in the low 12 bits |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench fills the bank with two different arithmetic patterns: one written through the data port and read back through the alias, the other written through the alias and read back through the data port. A mismatch therefore separates a broken path from a broken alias offset. Every index value from 00h to FFh is written and read back. All out-of-range index values are driven against the data port, and every unmapped memory offset is hit with a write and a read. Each of these sweeps is followed by a full readback of both register groups, so a stray write shows up as a changed location. Both resets are applied over banks filled with FFh, which exposes any sticky bit set wrongly against the default mask, and a read of the upper-address alias confirms the 12-bit decode.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

   // upper bound on bank size; also sizes the sticky-mask parameter
   localparam int MAX_REGS = 256;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_INDEX = 2'd1,
      TGT_BANK  = 2'd2,
      TGT_SOCK  = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e       tgt;
      logic [7:0] sel;
   } route_t;

endpackage

// File: rtl/lcr_decode.sv
module lcr_decode
   import lcr_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int WIN_W      = 12,
   parameter int IO_BASE    = 'h3E0,
   parameter int ALIAS_OFS  = 'h800,
   parameter int NREG       = 64,
   parameter int SOCK_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_glob_n,
   input  logic              io_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        index,
   output route_t            route
);

   localparam logic [ADDR_W-1:0] IO_IDX_A  = ADDR_W'(IO_BASE);
   localparam logic [ADDR_W-1:0] IO_DAT_A  = ADDR_W'(IO_BASE + 1);
   localparam logic [WIN_W:0]    SOCK_END  = (WIN_W+1)'(SOCK_BYTES);
   localparam logic [WIN_W:0]    ALIAS_LO  = (WIN_W+1)'(ALIAS_OFS);
   localparam logic [WIN_W:0]    ALIAS_END = (WIN_W+1)'(ALIAS_OFS + NREG);
   localparam logic [8:0]        NREG_X    = 9'(NREG);

   if (WIN_W < 8 || ADDR_W < WIN_W) begin : g_bad_width
      $error("lcr_decode: window width must be >= 8 and <= address width");
   end
   if (ALIAS_OFS + NREG > (1 << WIN_W)) begin : g_bad_alias
      $error("lcr_decode: register alias does not fit in the window");
   end
   if (SOCK_BYTES > ALIAS_OFS) begin : g_bad_sock
      $error("lcr_decode: socket group overlaps the register alias");
   end

   logic [WIN_W:0] off_x;
   logic [WIN_W:0] rel;

   assign off_x = {1'b0, addr[WIN_W-1:0]};
   assign rel   = off_x - ALIAS_LO;

   always_comb begin
      route.tgt = TGT_NONE;
      route.sel = '0;
      if (io_sel) begin
         if (addr == IO_IDX_A) begin
            route.tgt = TGT_INDEX;
         end else if (addr == IO_DAT_A) begin
            if ({1'b0, index} < NREG_X) begin
               route.tgt = TGT_BANK;
               route.sel = index;
            end
         end
      end else begin
         if (off_x < SOCK_END) begin
            route.tgt = TGT_SOCK;
            route.sel = off_x[7:0];
         end else if (off_x >= ALIAS_LO && off_x < ALIAS_END) begin
            route.tgt = TGT_BANK;
            route.sel = rel[7:0];
         end
      end
   end

   // R3: a bank selection never points past the last register
   p_bank_sel_range_r3 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      (route.tgt == TGT_BANK) |-> ({1'b0, route.sel} < NREG_X));

   // R6: the index port only exists on the I/O path
   p_index_io_only_r6 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      (route.tgt == TGT_INDEX) |-> io_sel);

endmodule

// File: rtl/lcr_index.sv
module lcr_index #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_glob_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("lcr_index: width must be positive");
   end

   // only the global reset touches the index
   always_ff @(posedge clk) begin
      if (!rst_glob_n)  q <= '0;
      else if (ld)      q <= d;
   end

   p_index_load_r1 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      ld |=> (q == $past(d)));

   p_index_hold_r8 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      !ld |=> $stable(q));

endmodule

// File: rtl/lcr_bank.sv
module lcr_bank #(
   parameter int               NREG      = 64,
   parameter logic [NREG*8-1:0] KEEP_MASK = '0
) (
   input  logic       clk,
   input  logic       rst_glob_n,
   input  logic       rst_pwr_n,
   input  logic       we,
   input  logic [7:0] wsel,
   input  logic [7:0] wdata,
   input  logic [7:0] rsel,
   output logic [7:0] rdata
);

   localparam int          SEL_W  = (NREG > 1) ? $clog2(NREG) : 1;
   localparam logic [8:0]  NREG_X = 9'(NREG);

   if (NREG < 2 || NREG > 256 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("lcr_bank: register count must be a power of two in 2..256");
   end

   logic [NREG*8-1:0] flat;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [7:0] KM = KEEP_MASK[8*g +: 8];
      logic       hit;
      logic [7:0] r;

      assign hit = we && (wsel == 8'(g));

      if (KM == 8'h00) begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_glob_n || !rst_pwr_n) r <= '0;
            else if (hit)                  r <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (!rst_glob_n)     r <= '0;
            else if (!rst_pwr_n) r <= r & KM;
            else if (hit)        r <= wdata;
         end
      end

      assign flat[8*g +: 8] = r;
   end

   assign rdata = flat[8*rsel[SEL_W-1:0] +: 8];

   // R8: ordinary reset spares the sticky bits
   p_sticky_keep_r8 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      !rst_pwr_n |=> ((flat & KEEP_MASK) == $past(flat & KEEP_MASK)));

   // R8: ordinary reset clears every other bit
   p_plain_clear_r8 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      !rst_pwr_n |=> ((flat & ~KEEP_MASK) == '0));

   // R2: an accepted write lands in the selected register
   p_write_lands_r2 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      (rst_pwr_n && we && ({1'b0, wsel} < NREG_X))
      |=> (flat[8*$past(wsel[SEL_W-1:0]) +: 8] == $past(wdata)));

   // R2: with no write and no reset, contents stay put
   p_idle_stable_r2 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      (rst_pwr_n && !we) |=> $stable(flat));

endmodule

// File: rtl/lcr_regfile.sv
module lcr_regfile
   import lcr_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int WIN_W      = 12,
   parameter int IO_BASE    = 'h3E0,
   parameter int ALIAS_OFS  = 'h800,
   parameter int NREG       = 64,
   parameter int SOCK_BYTES = 32,
   parameter logic [8*MAX_REGS-1:0] STICKY_MASK =
      ((8*MAX_REGS)'(8'h0F) << (8 * 5)) | ((8*MAX_REGS)'(8'hF0) << (8 * 32))
) (
   input  logic              clk,
   input  logic              rst_glob_n,
   input  logic              rst_pwr_n,
   input  logic              bus_io,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata
);

   if (NREG > MAX_REGS) begin : g_bad_nreg
      $error("lcr_regfile: register count exceeds the sticky mask width");
   end

   route_t     route;
   logic [7:0] idx_q;
   logic [7:0] bank_rd;
   logic [7:0] sock_rd;
   logic [7:0] rd_next;
   logic       idx_ld;
   logic       bank_we;
   logic       sock_we;

   lcr_decode #(
      .ADDR_W     (ADDR_W),
      .WIN_W      (WIN_W),
      .IO_BASE    (IO_BASE),
      .ALIAS_OFS  (ALIAS_OFS),
      .NREG       (NREG),
      .SOCK_BYTES (SOCK_BYTES)
   ) u_decode (
      .clk        (clk),
      .rst_glob_n (rst_glob_n),
      .io_sel     (bus_io),
      .addr       (bus_addr),
      .index      (idx_q),
      .route      (route)
   );

   assign idx_ld  = bus_wr && (route.tgt == TGT_INDEX);
   assign bank_we = bus_wr && (route.tgt == TGT_BANK);
   assign sock_we = bus_wr && (route.tgt == TGT_SOCK);

   lcr_index #(.W(8)) u_index (
      .clk        (clk),
      .rst_glob_n (rst_glob_n),
      .ld         (idx_ld),
      .d          (bus_wdata),
      .q          (idx_q)
   );

   lcr_bank #(
      .NREG      (NREG),
      .KEEP_MASK (STICKY_MASK[NREG*8-1:0])
   ) u_bank (
      .clk        (clk),
      .rst_glob_n (rst_glob_n),
      .rst_pwr_n  (rst_pwr_n),
      .we         (bank_we),
      .wsel       (route.sel),
      .wdata      (bus_wdata),
      .rsel       (route.sel),
      .rdata      (bank_rd)
   );

   lcr_bank #(
      .NREG      (SOCK_BYTES),
      .KEEP_MASK ('0)
   ) u_sock (
      .clk        (clk),
      .rst_glob_n (rst_glob_n),
      .rst_pwr_n  (rst_pwr_n),
      .we         (sock_we),
      .wsel       (route.sel),
      .wdata      (bus_wdata),
      .rsel       (route.sel),
      .rdata      (sock_rd)
   );

   always_comb begin
      unique case (route.tgt)
         TGT_INDEX: rd_next = idx_q;
         TGT_BANK:  rd_next = bank_rd;
         TGT_SOCK:  rd_next = sock_rd;
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_glob_n || !rst_pwr_n) bus_rdata <= '0;
      else if (bus_rd)               bus_rdata <= rd_next;
   end

   // R6: unmapped reads return zero
   p_dead_read_zero_r6 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      (bus_rd && route.tgt == TGT_NONE) |=> (bus_rdata == 8'h00));

   // R7: read data holds between read strobes
   p_rdata_hold_r7 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      (!bus_rd && rst_pwr_n) |=> $stable(bus_rdata));

   // R1: an index-port read returns the index
   p_index_read_r1 : assert property (@(posedge clk) disable iff (!rst_glob_n)
      (bus_rd && rst_pwr_n && route.tgt == TGT_INDEX) |=> (bus_rdata == $past(idx_q)));

endmodule

// File: tb/lcr_regfile_bench.sv
module lcr_regfile_bench;

   localparam int    IOB  = 'h3E0;
   localparam int    NREG = 64;
   localparam int    NSCK = 32;

   logic        clk = 1'b0;
   logic        rst_glob_n = 1'b0;
   logic        rst_pwr_n  = 1'b0;
   logic        bus_io = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   lcr_regfile u_lcr_regfile (
      .clk        (clk),
      .rst_glob_n (rst_glob_n),
      .rst_pwr_n  (rst_pwr_n),
      .bus_io     (bus_io),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata)
   );

   always #5 clk = ~clk;

   function automatic logic [7:0] pat_io(int n);
      return 8'((n * 7 + 'h35) & 'hFF);
   endfunction
   function automatic logic [7:0] pat_mem(int n);
      return 8'(~n) ^ 8'h5A;
   endfunction
   function automatic logic [7:0] pat_sock(int n);
      return 8'(n) ^ 8'hC3;
   endfunction
   function automatic logic [7:0] keep_of(int n);
      if (n == 5)  return 8'h0F;
      if (n == 32) return 8'hF0;
      return 8'h00;
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input bit io, input int a, input logic [7:0] d);
      @(negedge clk);
      bus_io = io; bus_addr = 16'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input bit io, input int a, output logic [7:0] d);
      @(negedge clk);
      bus_io = io; bus_addr = 16'(a); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic io_reg_rd(input int n, output logic [7:0] d);
      wr(1'b1, IOB, 8'(n));
      rd(1'b1, IOB + 1, d);
   endtask

   task automatic verify_all(input string tag, input logic [7:0] bexp [NREG],
                             input logic [7:0] sexp [NSCK]);
      logic [7:0] v;
      for (int n = 0; n < NREG; n++) begin
         rd(1'b0, 'h800 + n, v);
         check(tag, v, bexp[n]);
      end
      for (int n = 0; n < NSCK; n++) begin
         rd(1'b0, n, v);
         check(tag, v, sexp[n]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: got hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] bm [NREG];
      logic [7:0] sm [NSCK];

      repeat (3) @(negedge clk);
      rst_glob_n = 1'b1;
      rst_pwr_n  = 1'b1;

      // R9: state after global reset
      check("R9 rdata after reset", bus_rdata, 8'h00);
      rd(1'b1, IOB, v);
      check("R9 index after reset", v, 8'h00);

      // R1: every index value loads and reads back
      for (int i = 0; i < 256; i++) begin
         wr(1'b1, IOB, 8'(i));
         rd(1'b1, IOB, v);
         check("R1 index readback", v, 8'(i));
      end

      // R2 / R4: write through data port, read through alias
      for (int n = 0; n < NREG; n++) begin
         wr(1'b1, IOB, 8'(n));
         wr(1'b1, IOB + 1, pat_io(n));
      end
      for (int n = 0; n < NREG; n++) begin
         rd(1'b0, 'h800 + n, v);
         check("R4 alias sees data-port write", v, pat_io(n));
      end
      // R4 / R2: write through alias, read through data port
      for (int n = 0; n < NREG; n++) begin
         wr(1'b0, 'h800 + n, pat_mem(n));
         bm[n] = pat_mem(n);
      end
      for (int n = 0; n < NREG; n++) begin
         io_reg_rd(n, v);
         check("R2 data port sees alias write", v, pat_mem(n));
      end

      // R5: socket group is separate storage
      for (int n = 0; n < NSCK; n++) begin
         wr(1'b0, n, pat_sock(n));
         sm[n] = pat_sock(n);
      end
      verify_all("R5 socket group separate", bm, sm);

      // R3: out-of-range index reads zero and ignores writes
      for (int i = NREG; i < 256; i++) begin
         wr(1'b1, IOB, 8'(i));
         wr(1'b1, IOB + 1, 8'hA5);
         rd(1'b1, IOB + 1, v);
         check("R3 out-of-range data read", v, 8'h00);
      end
      verify_all("R3 out-of-range write ignored", bm, sm);

      // R6: unmapped memory offsets
      for (int a = NSCK; a < 'h800; a++) begin
         wr(1'b0, a, 8'h77);
         rd(1'b0, a, v);
         check("R6 gap below alias", v, 8'h00);
      end
      for (int a = 'h800 + NREG; a < 'h1000; a++) begin
         wr(1'b0, a, 8'h77);
         rd(1'b0, a, v);
         check("R6 gap above alias", v, 8'h00);
      end
      verify_all("R6 gap writes ignored", bm, sm);

      // R6: other I/O addresses
      wr(1'b1, IOB, 8'h12);
      wr(1'b1, IOB + 2, 8'h3C);
      rd(1'b1, IOB + 2, v);
      check("R6 io base+2 reads zero", v, 8'h00);
      wr(1'b1, IOB - 1, 8'h3C);
      rd(1'b1, IOB - 1, v);
      check("R6 io base-1 reads zero", v, 8'h00);
      rd(1'b1, IOB, v);
      check("R6 index untouched by other io", v, 8'h12);
      verify_all("R6 io writes ignored", bm, sm);

      // R10: upper address bits ignored on the memory path
      rd(1'b0, 'h1805, v);
      check("R10 high alias", v, bm[5]);
      wr(1'b0, 'hF805, 8'h9E);
      bm[5] = 8'h9E;
      io_reg_rd(5, v);
      check("R10 high alias write", v, 8'h9E);

      // R7: read data holds without a strobe
      rd(1'b0, 'h800 + 9, v);
      check("R7 read data", v, bm[9]);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R7 read data holds", bus_rdata, bm[9]);
      end

      // R8: ordinary reset over all-ones contents
      for (int n = 0; n < NREG; n++) wr(1'b0, 'h800 + n, 8'hFF);
      for (int n = 0; n < NSCK; n++) wr(1'b0, n, 8'hFF);
      wr(1'b1, IOB, 8'h2A);
      rd(1'b0, 'h800, v);
      @(negedge clk);
      rst_pwr_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_pwr_n = 1'b1;
      check("R8 rdata cleared", bus_rdata, 8'h00);
      rd(1'b1, IOB, v);
      check("R8 index kept", v, 8'h2A);
      for (int n = 0; n < NREG; n++) bm[n] = keep_of(n);
      for (int n = 0; n < NSCK; n++) sm[n] = 8'h00;
      verify_all("R8 sticky bits kept, rest cleared", bm, sm);

      // R9: global reset clears sticky bits and index
      for (int n = 0; n < NREG; n++) wr(1'b0, 'h800 + n, 8'hFF);
      for (int n = 0; n < NSCK; n++) wr(1'b0, n, 8'hFF);
      wr(1'b1, IOB, 8'h33);
      @(negedge clk);
      rst_glob_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_glob_n = 1'b1;
      check("R9 rdata cleared", bus_rdata, 8'h00);
      rd(1'b1, IOB, v);
      check("R9 index cleared", v, 8'h00);
      for (int n = 0; n < NREG; n++) bm[n] = 8'h00;
      verify_all("R9 all bits cleared", bm, sm);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule